// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

The block narrows a 32-bit IEEE-754 binary32 word to a 16-bit binary16 word in one clock. Every accepted input, marked by an input valid strobe, gives a result in the output register on the next rising edge, together with an output valid bit. A 2-bit select picks the rounding rule for each word separately, so words that need different rounding can share one converter on consecutive cycles.

The datapath first sorts the input into a class: special (infinity or NaN), overflow, underflow, subnormal result or normal result. A shift of the 24-bit significand then yields the kept bits, a guard bit and a sticky bit. The rounding increment is added to the packed exponent-and-fraction value, so a carry out of the fraction moves into the exponent and can reach infinity. Results that saturate or flush depend on the sign and on the direction of the selected rounding rule.

Top module: `sp2hp_conv`

## Requirements
- R1: The mode select is coded as 0 = round toward minus infinity, 1 = round toward plus infinity, 2 = round to nearest with ties to even; code 3 behaves exactly like code 2.
- R2: An input with exponent field 255 gives the input sign with magnitude 0x7C00 when its fraction is zero; a nonzero fraction gives the input sign with magnitude 0x7E00, whatever the payload.
- R3: When input exponent minus 112 is 31 or more (and the input is not special), nearest mode gives signed infinity; a directed mode gives signed infinity if the sign agrees with the direction (positive with mode 1, negative with mode 0), else signed magnitude 0x7BFF.
- R4: When input exponent minus 112 is below -10, the result is signed zero, except that a directed mode whose direction agrees with the sign gives signed magnitude 0x0001 for a nonzero input.
- R5: When input exponent minus 112 lies in -10..0, the result has exponent field 0 and a fraction equal to the 24-bit significand (implicit one restored) shifted right by 14 minus that value, then rounded.
- R6: Otherwise the result exponent field (bits 14:10) is input exponent minus 112, the fraction (bits 9:0) is the top 10 input fraction bits, then rounded; the sign (bit 15) is copied.
- R7: In nearest mode the truncated result is incremented when the dropped bits exceed half a result LSB, or equal half an LSB while the kept LSB is 1.
- R8: In a directed mode the truncated result is incremented when any dropped bit is 1 and the sign agrees with the direction; otherwise it is truncated.
- R9: The increment is applied to the 15-bit exponent-and-fraction value, so a fraction carry raises the exponent, and 0x7BFF rounds up to 0x7C00.
- R10: A zero input of either sign yields the half zero of the same sign in every mode.
- R11: Output valid is set one clock after a cycle with input valid high and cleared one clock after a cycle with it low; synchronous reset clears output valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and mode are valid this cycle |
| in_word | input | 32 | binary32 operand |
| in_mode | input | 2 | Rounding rule select |
| out_valid | output | 1 | Output word is valid |
| out_half | output | 16 | binary16 result |

## Verification
Hand-picked words bracket each class boundary: the largest finite half and the first value above it, the exact half-LSB tie with even and odd kept bits, the smallest subnormal and the tie just below it, and the largest subnormal that carries into the smallest normal. Each is applied under several modes and both signs, which separates the nearest rule from the two directed rules and shows whether the sign steers saturation and flushing. Random words, half with exponents concentrated around the half-precision range, compare every class and mode against an arithmetic model that derives the result LSB weight rather than mimicking the shifter.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

    localparam int IN_EW    = 8;
    localparam int IN_MW    = 23;
    localparam int OUT_EW   = 5;
    localparam int OUT_MW   = 10;

    localparam int IN_W     = 1 + IN_EW + IN_MW;
    localparam int OUT_W    = 1 + OUT_EW + OUT_MW;
    localparam int MAG_W    = OUT_EW + OUT_MW;
    localparam int IN_BIAS  = (1 << (IN_EW - 1)) - 1;
    localparam int OUT_BIAS = (1 << (OUT_EW - 1)) - 1;
    localparam int REBIAS   = IN_BIAS - OUT_BIAS;
    localparam int OUT_EMAX = (1 << OUT_EW) - 1;
    localparam int NORM_SH  = IN_MW - OUT_MW;
    localparam int SIG_W    = IN_MW + 1;
    localparam int SH_W     = $clog2(SIG_W + 1);
    localparam int REB_W    = IN_EW + 2;

    localparam logic [MAG_W-1:0] MAG_INF    = MAG_W'(OUT_EMAX << OUT_MW);
    localparam logic [MAG_W-1:0] MAG_QNAN   = MAG_INF | MAG_W'(1 << (OUT_MW - 1));
    localparam logic [MAG_W-1:0] MAG_MAXFIN = MAG_INF - MAG_W'(1);
    localparam logic [MAG_W-1:0] MAG_MINSUB = MAG_W'(1);

    typedef enum logic [1:0] {
        RND_DOWN = 2'd0,
        RND_UP   = 2'd1,
        RND_NEAR = 2'd2,
        RND_RSVD = 2'd3
    } rnd_mode_e;

    typedef enum logic [2:0] {
        CL_SPECIAL,
        CL_OVER,
        CL_UNDER,
        CL_SUBN,
        CL_NORM
    } cls_e;

    typedef struct packed {
        logic sign;
        cls_e cls;
        logic is_nan;
        logic nonzero;
    } cls_info_t;

    typedef struct packed {
        logic [OUT_EW-1:0] exp_field;
        logic [SIG_W-1:0]  sig;
        logic [SH_W-1:0]   shamt;
    } path_t;

    function automatic logic mode_is_near(input rnd_mode_e m);
        return (m == RND_NEAR) || (m == RND_RSVD);
    endfunction

    // true when a directed rule moves away from zero for this sign
    function automatic logic dir_favours(input rnd_mode_e m, input logic s);
        return ((m == RND_UP) && !s) || ((m == RND_DOWN) && s);
    endfunction

endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
    import f2h_pkg::*;
(
    input  logic [IN_W-1:0] word_i,
    output cls_info_t       info_o,
    output path_t           path_o
);
    localparam logic signed [REB_W-1:0] REB_OVF  = REB_W'(OUT_EMAX);
    localparam logic signed [REB_W-1:0] REB_UNF  = REB_W'(-OUT_MW);
    localparam logic signed [REB_W-1:0] REB_OFS  = REB_W'(REBIAS);
    localparam logic signed [REB_W-1:0] SUB_BASE = REB_W'(NORM_SH + 1);

    logic [IN_EW-1:0]        e_raw;
    logic [IN_MW-1:0]        mant;
    logic signed [REB_W-1:0] reb;

    always_comb begin
        e_raw = word_i[IN_W-2 -: IN_EW];
        mant  = word_i[IN_MW-1:0];
        reb   = $signed({2'b00, e_raw}) - REB_OFS;

        info_o.sign    = word_i[IN_W-1];
        info_o.nonzero = |word_i[IN_W-2:0];
        info_o.is_nan  = (&e_raw) && (|mant);
        info_o.cls     = CL_NORM;

        path_o.sig       = {1'b1, mant};
        path_o.exp_field = '0;
        path_o.shamt     = SH_W'(NORM_SH);

        if (&e_raw) begin
            info_o.cls = CL_SPECIAL;
        end else if (reb >= REB_OVF) begin
            info_o.cls = CL_OVER;
        end else if (reb < REB_UNF) begin
            info_o.cls = CL_UNDER;
        end else if (reb[REB_W-1] || (reb == '0)) begin
            info_o.cls   = CL_SUBN;
            path_o.shamt = SH_W'(SUB_BASE - reb);
        end else begin
            path_o.exp_field = reb[OUT_EW-1:0];
        end
    end
endmodule

// File: rtl/f2h_round.sv
module f2h_round
    import f2h_pkg::*;
(
    input  logic             sign_i,
    input  path_t            path_i,
    input  rnd_mode_e        mode_i,
    output logic [MAG_W-1:0] mag_o
);
    logic [OUT_MW-1:0] kept;
    logic [SIG_W-1:0]  dropped;
    logic              guard;
    logic              sticky;
    logic              inc;
    logic [MAG_W-1:0]  trunc;

    always_comb begin
        kept    = OUT_MW'(path_i.sig >> path_i.shamt);
        dropped = SIG_W'({path_i.sig, {SIG_W{1'b0}}} >> path_i.shamt);
        guard   = dropped[SIG_W-1];
        sticky  = |dropped[SIG_W-2:0];

        if (mode_is_near(mode_i))
            inc = guard && (sticky || kept[0]);
        else
            inc = (guard || sticky) && dir_favours(mode_i, sign_i);

        // carry may ripple from fraction into exponent
        trunc = {path_i.exp_field, kept};
        mag_o = trunc + MAG_W'(inc);
    end
endmodule

// File: rtl/f2h_select.sv
module f2h_select
    import f2h_pkg::*;
(
    input  cls_info_t        info_i,
    input  rnd_mode_e        mode_i,
    input  logic [MAG_W-1:0] rounded_i,
    output logic [OUT_W-1:0] half_o
);
    logic             near;
    logic             fav;
    logic [MAG_W-1:0] mag;

    always_comb begin
        near = mode_is_near(mode_i);
        fav  = dir_favours(mode_i, info_i.sign);
        unique case (info_i.cls)
            CL_SPECIAL: mag = info_i.is_nan ? MAG_QNAN : MAG_INF;
            CL_OVER:    mag = (near || fav) ? MAG_INF : MAG_MAXFIN;
            CL_UNDER:   mag = (!near && fav && info_i.nonzero) ? MAG_MINSUB : '0;
            default:    mag = rounded_i;
        endcase
        half_o = {info_i.sign, mag};
    end
endmodule

// File: rtl/sp2hp_conv.sv
module sp2hp_conv
    import f2h_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    input  logic [1:0]  in_mode,
    output logic        out_valid,
    output logic [15:0] out_half
);
    cls_info_t        info;
    path_t            path;
    rnd_mode_e        mode;
    logic [MAG_W-1:0] rounded;
    logic [OUT_W-1:0] half_c;

    assign mode = rnd_mode_e'(in_mode);

    f2h_classify u_cls (
        .word_i (in_word),
        .info_o (info),
        .path_o (path)
    );

    f2h_round u_rnd (
        .sign_i (info.sign),
        .path_i (path),
        .mode_i (mode),
        .mag_o  (rounded)
    );

    f2h_select u_sel (
        .info_i    (info),
        .mode_i    (mode),
        .rounded_i (rounded),
        .half_o    (half_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_half  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_half <= half_c;
        end
    end

    // ---------------- assertions ----------------
    p_valid_set_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_clr_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_inf_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&in_word[30:23]) && (in_word[22:0] == '0))
        |=> out_half == {$past(in_word[31]), MAG_INF});

    p_nan_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&in_word[30:23]) && (in_word[22:0] != '0))
        |=> out_half == {$past(in_word[31]), MAG_QNAN});

    p_zero_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_word[30:0] == '0)) |=> out_half == {$past(in_word[31]), 15'h0000});

    p_ovf_near_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (info.cls == CL_OVER) && in_mode[1]) |=> out_half[14:0] == MAG_INF);

    p_unf_near_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (info.cls == CL_UNDER) && in_mode[1]) |=> out_half[14:0] == 15'h0000);
endmodule

// File: tb/tb_sp2hp_conv.sv
`timescale 1ns/1ps
module tb_sp2hp_conv;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_word;
    logic [1:0]  in_mode;
    logic        out_valid;
    logic [15:0] out_half;

    int n_checks = 0;
    int n_errs   = 0;

    always #2 clk = ~clk;

    sp2hp_conv dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_half  (out_half)
    );

    // arithmetic model: find the weight of the result LSB, then round
    function automatic logic [15:0] model(input logic [31:0] w, input logic [1:0] m);
        logic   s;
        int     ex, eu, lsb_e, sh, enc;
        longint sig, kept, rem, half;
        logic   near, fav, inc;
        s    = w[31];
        ex   = int'(w[30:23]);
        near = m[1];
        fav  = (m == 2'd1 && !s) || (m == 2'd0 && s);
        if (ex == 255) return (w[22:0] == 0) ? {s, 15'h7C00} : {s, 15'h7E00};
        if (ex == 0) begin sig = longint'(w[22:0]); eu = -126; end
        else begin sig = longint'({1'b1, w[22:0]}); eu = ex - 127; end
        if (eu >= 16) return (near || fav) ? {s, 15'h7C00} : {s, 15'h7BFF};
        lsb_e = ((eu < -14) ? -14 : eu) - 10;
        sh    = lsb_e - (eu - 23);
        if (sh > 40) begin
            kept = 0;
            inc  = near ? 1'b0 : (fav && sig != 0);
        end else begin
            kept = sig >> sh;
            rem  = sig & ((64'sd1 <<< sh) - 1);
            half = 64'sd1 <<< (sh - 1);
            if (near) inc = (rem > half) || (rem == half && kept[0]);
            else      inc = (rem != 0) && fav;
        end
        enc = (eu >= -14) ? (((eu + 14) << 10) + int'(kept)) : int'(kept);
        enc = enc + int'(inc);
        return {s, enc[14:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // drive at a falling edge, result is registered at the next rising edge
    task automatic conv(input logic [31:0] w, input logic [1:0] m,
                        input logic [15:0] expv, input string req);
        in_valid = 1'b1;
        in_word  = w;
        in_mode  = m;
        @(negedge clk);
        chk(req, {16'h0, out_half}, {16'h0, expv});
    endtask

    initial begin
        #800000;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [1:0]  m;
        void'($urandom(32'h5EED_0F16));
        rst = 1'b1; in_valid = 1'b0; in_word = '0; in_mode = '0;
        repeat (3) @(negedge clk);
        chk("R11 reset", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;

        // R6 normal results
        conv(32'h3F800000, 2'd2, 16'h3C00, "R6 one");
        chk("R11 valid after input", {31'h0, out_valid}, 32'h1);
        conv(32'hC0200000, 2'd2, 16'hC100, "R6 -2.5");
        conv(32'h477FE000, 2'd2, 16'h7BFF, "R6 max finite");
        // R7 nearest ties and R1 reserved code
        conv(32'h3F801000, 2'd2, 16'h3C00, "R7 tie even");
        conv(32'h3F803000, 2'd2, 16'h3C02, "R7 tie odd");
        conv(32'h3F801000, 2'd3, 16'h3C00, "R1 code3 tie even");
        conv(32'h3F803000, 2'd3, 16'h3C02, "R1 code3 tie odd");
        // R8 directed
        conv(32'h3F801001, 2'd0, 16'h3C00, "R8 down positive");
        conv(32'h3F801001, 2'd1, 16'h3C01, "R8 up positive");
        conv(32'hBF801001, 2'd0, 16'hBC01, "R8 down negative");
        conv(32'hBF801001, 2'd1, 16'hBC00, "R8 up negative");
        // R9 carries
        conv(32'h477FF000, 2'd2, 16'h7C00, "R9 carry to inf");
        conv(32'h477FF000, 2'd0, 16'h7BFF, "R8 down no carry");
        conv(32'h387FF000, 2'd2, 16'h0400, "R9 subnormal to normal");
        // R3 overflow
        conv(32'h49742400, 2'd2, 16'h7C00, "R3 near");
        conv(32'h49742400, 2'd0, 16'h7BFF, "R3 down pos");
        conv(32'h49742400, 2'd1, 16'h7C00, "R3 up pos");
        conv(32'hC9742400, 2'd0, 16'hFC00, "R3 down neg");
        conv(32'hC9742400, 2'd1, 16'hFBFF, "R3 up neg");
        // R2 specials
        conv(32'h7FC00001, 2'd2, 16'h7E00, "R2 nan");
        conv(32'hFF812345, 2'd0, 16'hFE00, "R2 neg nan");
        conv(32'h7F800000, 2'd0, 16'h7C00, "R2 inf");
        conv(32'hFF800000, 2'd1, 16'hFC00, "R2 neg inf");
        // R4 underflow
        conv(32'h00000001, 2'd1, 16'h0001, "R4 up tiny");
        conv(32'h00000001, 2'd2, 16'h0000, "R4 near tiny");
        conv(32'h00000001, 2'd0, 16'h0000, "R4 down tiny");
        conv(32'h80000001, 2'd0, 16'h8001, "R4 down neg tiny");
        conv(32'h2E000000, 2'd1, 16'h0001, "R4 up small normal");
        // R10 zeros
        conv(32'h00000000, 2'd1, 16'h0000, "R10 pos zero");
        conv(32'h80000000, 2'd0, 16'h8000, "R10 neg zero");
        // R5 subnormal results
        conv(32'h33800000, 2'd2, 16'h0001, "R5 min subnormal");
        conv(32'h38000000, 2'd2, 16'h0200, "R5 half of min normal");
        conv(32'h33000000, 2'd2, 16'h0000, "R5 tie to zero");
        conv(32'h33000001, 2'd2, 16'h0001, "R5 above tie");

        // R11 idle cycle clears valid
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11 idle", {31'h0, out_valid}, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            w = $urandom;
            if (i % 2 == 1) w[30:23] = 8'(95 + $urandom_range(0, 55));
            m = 2'($urandom_range(0, 3));
            conv(w, m, model(w, m), "R5 R6 R7 R8 random");
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule